// File: doc/BRIEF.md
# Iterative integer divide and modulo unit

This unit serves the divide and modulo operations of a 64-bit register-based virtual instruction set. A single start strobe hands it one operation. The operation carries a destination operand and a divisor, which is taken either from a source register value or from a 32-bit immediate. Three control bits go with it: the operating width (32 or 64 bits), signed or unsigned treatment, and whether the quotient or the remainder is wanted. The unit returns the 64-bit value to be written back to the destination register, together with a one-cycle done pulse.

The core is a restoring shift-subtract engine. It works on operand magnitudes and produces one quotient bit per clock. A fix-up cycle then applies the result signs, substitutes the fixed division-by-zero results and zero-extends 32-bit results. A final writeback cycle presents the value at the registered output. Division by zero and signed overflow never trap: each gives a fixed, defined value. A start that arrives while an operation is in flight is dropped.

Top module: `idiv_unit`

## Requirements
- R1: For unsigned 64-bit operation (wide=1, is_signed=0), result is dst/divisor when want_rem=0 and dst%divisor when want_rem=1, for every nonzero divisor.
- R2: Signed operation (is_signed=1) truncates toward zero. The quotient is negative exactly when the operand signs differ, and a nonzero remainder carries the sign of the dividend.
- R3: In 32-bit mode (wide=0) only bits 31:0 of the dividend and of the divisor take part, with bit 31 as the sign bit, and bits 63:32 of every result are zero.
- R4: With use_imm=1 the divisor comes from imm_val instead of src_val. In 32-bit mode the immediate is used as is. In 64-bit mode it is sign-extended from 32 to 64 bits before use, in both the unsigned and the signed form. For example, 0xFFFFFFFF becomes 2^64-1 when unsigned.
- R5: A divisor of zero in the active width, with want_rem=0, yields result 0.
- R6: A divisor of zero with want_rem=1 in 64-bit mode yields the dividend dst unchanged.
- R7: A divisor of zero with want_rem=1 in 32-bit mode yields dst[31:0] with bits 63:32 cleared.
- R8: Signed division of the most negative value of the active width by -1 yields that most negative value, zero-extended in 32-bit mode, and the matching remainder is 0.
- R9: done is high for exactly one cycle. It rises N+2 clock edges after the edge that samples start (N=64 in 64-bit mode, N=32 in 32-bit mode), and result holds the writeback value from then until the next operation completes.
- R10: From the edge that accepts start until the edge that raises done, busy is 1. A start in that window is ignored and changes neither the result nor its timing.
- R11: After reset, done=0, busy=0 and result=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| is_signed | input | 1 | 1 = signed, 0 = unsigned |
| want_rem | input | 1 | 1 = remainder, 0 = quotient |
| use_imm | input | 1 | 1 = divisor from imm_val, 0 = from src_val |
| dst_val | input | 64 | Destination operand (dividend) |
| src_val | input | 64 | Source register operand |
| imm_val | input | 32 | Immediate operand |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 64 | Destination writeback value |

## Verification
The effects of a bad internal state appear at the ports in a few distinct ways. A wrong iteration count shows up as a done pulse that arrives early or late against the N+2 edge rule. A corrupted partial remainder or misloaded 32-bit dividend produces a wrong quotient or remainder on that same pulse, and these are compared against a model built from the requirements. Flags latched from the wrong inputs show up as wrong signs, wrong division-by-zero values or nonzero upper bits at the next done. A start that leaks into a running operation appears at the pulse of the running operation as a changed value or a shifted arrival.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIX,
    ST_WB
  } idiv_state_e;

  // per-operation flags captured when start is accepted
  typedef struct packed {
    logic wide;
    logic want_rem;
    logic neg_q;
    logic neg_r;
    logic div_zero;
  } idiv_ctl_t;

endpackage

// File: rtl/idiv_prep.sv
module idiv_prep #(
  parameter int XLEN = 64
) (
  input  logic              wide,
  input  logic              is_signed,
  input  logic              use_imm,
  input  logic [XLEN-1:0]   dst,
  input  logic [XLEN-1:0]   src,
  input  logic [XLEN/2-1:0] imm,
  output logic [XLEN-1:0]   mag_a,
  output logic [XLEN-1:0]   mag_b,
  output logic              neg_q,
  output logic              neg_r,
  output logic              div_zero
);
  localparam int HLEN = XLEN / 2;

  logic [XLEN-1:0] dvs_full;
  logic [XLEN-1:0] a_w, b_w, a_inv, b_inv;
  logic            sa, sb;

  always_comb begin
    if (use_imm)
      dvs_full = wide ? {{HLEN{imm[HLEN-1]}}, imm} : {{HLEN{1'b0}}, imm};
    else
      dvs_full = src;

    a_w = wide ? dst      : {{HLEN{1'b0}}, dst[HLEN-1:0]};
    b_w = wide ? dvs_full : {{HLEN{1'b0}}, dvs_full[HLEN-1:0]};

    sa = is_signed & (wide ? dst[XLEN-1]      : dst[HLEN-1]);
    sb = is_signed & (wide ? dvs_full[XLEN-1] : dvs_full[HLEN-1]);

    a_inv = ~a_w + 1'b1;
    b_inv = ~b_w + 1'b1;

    if (sa) mag_a = wide ? a_inv : {{HLEN{1'b0}}, a_inv[HLEN-1:0]};
    else    mag_a = a_w;
    if (sb) mag_b = wide ? b_inv : {{HLEN{1'b0}}, b_inv[HLEN-1:0]};
    else    mag_b = b_w;

    neg_q    = sa ^ sb;
    neg_r    = sa;
    div_zero = (b_w == '0);
  end

endmodule

// File: rtl/idiv_core.sv
module idiv_core #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            wide,
  input  logic [XLEN-1:0] mag_a,
  input  logic [XLEN-1:0] mag_b,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rem,
  output logic            last
);
  localparam int HLEN = XLEN / 2;
  localparam int CW   = $clog2(XLEN + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(XLEN);
  localparam logic [CW-1:0] HALF_CNT = CW'(HLEN);

  logic [XLEN-1:0] quo_q, rem_q, dvs_q;
  logic [CW-1:0]   cnt_q;
  logic [XLEN:0]   trial;
  logic [XLEN+1:0] diff;
  logic            borrow;

  always_comb begin
    trial  = {rem_q, quo_q[XLEN-1]};
    diff   = {1'b0, trial} - {2'b00, dvs_q};
    borrow = diff[XLEN+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      quo_q <= wide ? mag_a : {mag_a[HLEN-1:0], {HLEN{1'b0}}};
      rem_q <= '0;
      dvs_q <= mag_b;
      cnt_q <= wide ? FULL_CNT : HALF_CNT;
    end else if (cnt_q != '0) begin
      quo_q <= {quo_q[XLEN-2:0], ~borrow};
      rem_q <= borrow ? trial[XLEN-1:0] : diff[XLEN-1:0];
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign quo  = quo_q;
  assign rem  = rem_q;
  assign last = (cnt_q == CW'(1));

  // R1
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (dvs_q != '0) |-> (rem_q < dvs_q));

  // R10
  load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (cnt_q == '0));

endmodule

// File: rtl/idiv_unit.sv
module idiv_unit
  import idiv_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wide,
  input  logic              is_signed,
  input  logic              want_rem,
  input  logic              use_imm,
  input  logic [XLEN-1:0]   dst_val,
  input  logic [XLEN-1:0]   src_val,
  input  logic [XLEN/2-1:0] imm_val,
  output logic              busy,
  output logic              done,
  output logic [XLEN-1:0]   result
);
  localparam int HLEN = XLEN / 2;

  idiv_state_e     state;
  idiv_ctl_t       ctl_q;
  logic [XLEN-1:0] dst_q, fix_q, fix_val;
  logic [XLEN-1:0] mag_a, mag_b, quo, rem;
  logic            p_neg_q, p_neg_r, p_dz, load, last;
  logic [XLEN-1:0] q_signed, r_signed, pick;

  assign load = start && (state == ST_IDLE);

  idiv_prep #(.XLEN(XLEN)) u_prep (
    .wide(wide), .is_signed(is_signed), .use_imm(use_imm),
    .dst(dst_val), .src(src_val), .imm(imm_val),
    .mag_a(mag_a), .mag_b(mag_b),
    .neg_q(p_neg_q), .neg_r(p_neg_r), .div_zero(p_dz)
  );

  idiv_core #(.XLEN(XLEN)) u_core (
    .clk(clk), .rst(rst), .load(load), .wide(wide),
    .mag_a(mag_a), .mag_b(mag_b),
    .quo(quo), .rem(rem), .last(last)
  );

  always_comb begin
    q_signed = ctl_q.neg_q ? (~quo + 1'b1) : quo;
    r_signed = ctl_q.neg_r ? (~rem + 1'b1) : rem;
    if (ctl_q.div_zero)
      pick = ctl_q.want_rem ? dst_q : '0;
    else
      pick = ctl_q.want_rem ? r_signed : q_signed;
    fix_val = ctl_q.wide ? pick : {{HLEN{1'b0}}, pick[HLEN-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ctl_q  <= '0;
      dst_q  <= '0;
      fix_q  <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          ctl_q.wide     <= wide;
          ctl_q.want_rem <= want_rem;
          ctl_q.neg_q    <= p_neg_q;
          ctl_q.neg_r    <= p_neg_r;
          ctl_q.div_zero <= p_dz;
          dst_q          <= dst_val;
          state          <= ST_RUN;
        end
        ST_RUN: if (last) state <= ST_FIX;
        ST_FIX: begin
          fix_q <= fix_val;
          state <= ST_WB;
        end
        ST_WB: begin
          result <= fix_q;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && start) |=> (state != ST_IDLE));

  // R3
  narrow_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !ctl_q.wide) |-> (result[XLEN-1:HLEN] == '0));

  // R5
  dz_quot_chk: assert property (@(posedge clk) disable iff (rst)
    (done && ctl_q.div_zero && !ctl_q.want_rem) |-> (result == '0));

endmodule

// File: tb/tb_idiv_unit.sv
`timescale 1ns/1ps
module tb_idiv_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, wide = 1'b0, is_signed = 1'b0, want_rem = 1'b0, use_imm = 1'b0;
  logic [63:0] dst_val = '0, src_val = '0;
  logic [31:0] imm_val = '0;
  logic        busy, done;
  logic [63:0] result;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [63:0] q_val[$];
  int          q_cyc[$];
  string       q_tag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  idiv_unit dut (.clk, .rst, .start, .wide, .is_signed, .want_rem, .use_imm,
                 .dst_val, .src_val, .imm_val, .busy, .done, .result);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(bit w, bit s, bit r, bit ui,
                                        logic [63:0] d, logic [63:0] sr, logic [31:0] im);
    logic [63:0] dv, q64, r64;
    logic [31:0] a, b, q32, r32;
    longint la, lb;
    int ia, ib;
    dv = ui ? (w ? {{32{im[31]}}, im} : {32'h0, im}) : sr;
    if (w) begin
      if (dv == 0) return r ? d : 64'h0;
      if (s) begin
        if (d == 64'h8000_0000_0000_0000 && dv == '1) return r ? 64'h0 : d;
        la = longint'(d); lb = longint'(dv);
        q64 = 64'(la / lb); r64 = 64'(la % lb);
      end else begin
        q64 = d / dv; r64 = d % dv;
      end
      return r ? r64 : q64;
    end
    a = d[31:0]; b = dv[31:0];
    if (b == 0) return r ? {32'h0, a} : 64'h0;
    if (s) begin
      if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return r ? 64'h0 : {32'h0, a};
      ia = int'(a); ib = int'(b);
      q32 = 32'(ia / ib); r32 = 32'(ia % ib);
    end else begin
      q32 = a / b; r32 = a % b;
    end
    return {32'h0, r ? r32 : q32};
  endfunction

  task automatic issue(string tag, bit w, bit s, bit r, bit ui,
                       logic [63:0] d, logic [63:0] sr, logic [31:0] im);
    @(negedge clk);
    wide = w; is_signed = s; want_rem = r; use_imm = ui;
    dst_val = d; src_val = sr; imm_val = im; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    q_val.push_back(model(w, s, r, ui, d, sr, im));
    q_cyc.push_back(cyc + (w ? 64 : 32) + 2);
    q_tag.push_back(tag);
  endtask

  task automatic drain();
    while (q_val.size() != 0) @(negedge clk);
  endtask

  task automatic run(string tag, bit w, bit s, bit r, bit ui,
                     logic [63:0] d, logic [63:0] sr, logic [31:0] im);
    issue(tag, w, s, r, ui, d, sr, im);
    drain();
  endtask

  // monitor: pops expected items as done pulses appear; timing checks R9
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q_val.size() == 0) begin
        check("R9 unexpected done", 64'h1, 64'h0);
      end else begin
        check(q_tag[0], result, q_val[0]);
        check("R9 latency", 64'(cyc), 64'(q_cyc[0]));
        void'(q_val.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 done", 64'(done), 64'h0);
    check("R11 busy", 64'(busy), 64'h0);
    check("R11 result", result, 64'h0);

    // R1 unsigned 64-bit
    run("R1 q", 1, 0, 0, 0, 64'd100, 64'd7, 0);
    run("R1 r", 1, 0, 1, 0, 64'd100, 64'd7, 0);
    run("R1 big q", 1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0001, 0);
    run("R1 big r", 1, 0, 1, 0, 64'hFEDC_BA98_7654_3210, 64'h0000_0012_3456_789B, 0);
    run("R1 small dividend", 1, 0, 1, 0, 64'd5, 64'hFFFF_0000_0000_0000, 0);

    // R2 signed truncation
    run("R2 neg/pos q", 1, 1, 0, 0, -64'sd100, 64'd7, 0);
    run("R2 neg/pos r", 1, 1, 1, 0, -64'sd100, 64'd7, 0);
    run("R2 pos/neg q", 1, 1, 0, 0, 64'd100, -64'sd7, 0);
    run("R2 pos/neg r", 1, 1, 1, 0, 64'd100, -64'sd7, 0);
    run("R2 neg/neg r", 1, 1, 1, 0, -64'sd100, -64'sd7, 0);

    // R3 32-bit mode ignores upper bits, zero-extends
    run("R3 u32 q", 0, 0, 0, 0, 64'hDEAD_BEEF_0000_0064, 64'h1234_0000_0000_0007, 0);
    run("R3 s32 q", 0, 1, 0, 0, 64'h0000_0001_FFFF_FF9C, 64'hFFFF_FFFF_0000_0007, 0);
    run("R3 s32 r", 0, 1, 1, 0, 64'h0000_0000_FFFF_FF9C, 64'h0000_0000_0000_0007, 0);

    // R4 immediate widening
    run("R4 u32 imm", 0, 0, 0, 1, 64'h0000_0000_FFFF_FFFF, 64'd3, 32'hFFFF_FFFF);
    run("R4 u64 imm sext q", 1, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 32'hFFFF_FFFF);
    run("R4 u64 imm sext r", 1, 0, 1, 1, 64'h0000_0000_8000_0000, 64'd3, 32'hFFFF_FFFF);
    run("R4 s64 imm", 1, 1, 0, 1, 64'd100, 64'd3, 32'hFFFF_FFF9);

    // R5 divide by zero
    run("R5 u64 q", 1, 0, 0, 0, 64'h1234, 64'h0, 0);
    run("R5 s32 q", 0, 1, 0, 0, 64'h1234, 64'hFFFF_FFFF_0000_0000, 0);
    run("R5 imm q", 1, 1, 0, 1, 64'h55, 64'h9, 32'h0);

    // R6 64-bit modulo by zero keeps dst
    run("R6 u64 r", 1, 0, 1, 0, 64'hCAFE_F00D_1234_5678, 64'h0, 0);
    run("R6 s64 r", 1, 1, 1, 1, 64'h8765_4321_0FED_CBA9, 64'h7, 32'h0);

    // R7 32-bit modulo by zero keeps low half only
    run("R7 u32 r", 0, 0, 1, 0, 64'hCAFE_F00D_1234_5678, 64'hAAAA_AAAA_0000_0000, 0);
    run("R7 s32 r", 0, 1, 1, 1, 64'hFFFF_FFFF_8000_0001, 64'h7, 32'h0);

    // R8 most negative by -1
    run("R8 s64 q", 1, 1, 0, 1, 64'h8000_0000_0000_0000, 64'h0, 32'hFFFF_FFFF);
    run("R8 s64 r", 1, 1, 1, 0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    run("R8 s32 q", 0, 1, 0, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 0);
    run("R8 s32 r", 0, 1, 1, 1, 64'h0000_0000_8000_0000, 64'h0, 32'hFFFF_FFFF);

    // R10 start while busy is ignored
    issue("R10 held result", 1, 0, 0, 0, 64'd1000, 64'd10, 0);
    repeat (5) @(negedge clk);
    check("R10 busy", 64'(busy), 64'h1);
    wide = 0; want_rem = 1; dst_val = 64'd77; src_val = 64'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (3) @(negedge clk);
    check("R10 idle after", 64'(busy), 64'h0);
    check("R9 result held", result, 64'd100);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule